// File: doc/BRIEF.md
# 100 Mb/s Receive Code-Group Decoder

This block sits behind the symbol aligner and descrambler of a 100 Mb/s twisted-pair receiver. It takes one aligned 5-bit code group on every receive clock and produces the nibble-wide receive signals that a MAC expects: a data nibble, a data-valid flag, a receive-error flag and carrier sense. It recognises the start-of-stream pair and opens a frame. It translates data code groups into nibbles while the frame lasts. It closes the frame on the end-of-stream pair, or on idle that arrives without that pair.

The MAC samples the outputs on the rising clock edge, so the block updates them on the falling edge. The code-group input is a continuous line stream with no handshake. The line cannot be paused, so back-pressure is not possible: the block accepts a code group at every rising edge and never stalls. On the output side the MAC must likewise take a nibble on every clock.

Top module: `rx100_sym_decoder`

## Requirements
- R1: While `rst` is high and in the idle state, `rxdv_o`, `crs_o` and `rxer_o` are 0 and `rxd_o` is 0. In the idle state, any code group other than J (11000) is ignored and leaves these outputs at 0.
- R2: A J code group (11000) followed on the next clock by K (10001) opens a frame. `crs_o` and `rxdv_o` go high for the J cycle and stay high. The J cycle and the K cycle each output nibble 0x5.
- R3: A J followed by any code group other than K is a false carrier. For that one cycle `rxer_o` is 1, `rxd_o` is 4'b1110 and `rxdv_o` and `crs_o` are 0. The decoder then returns to idle.
- R4: Inside a frame, the data code groups map to nibbles as follows, with the code group written MSB first: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. Each of these cycles has `rxdv_o` and `crs_o` high and `rxer_o` low.
- R5: Inside a frame, any code group that is not data, T, or IDLE is invalid. This includes J, K, R and the unassigned groups. For that cycle `rxer_o` is 1 and `rxd_o` is 4'b1110, while `rxdv_o` and `crs_o` stay high and the frame continues.
- R6: A T code group (01101) followed by R (00111) ends the frame cleanly. The T cycle has `rxdv_o` low and `crs_o` high. The R cycle has `crs_o` low. Neither cycle raises `rxer_o`.
- R7: IDLE (11111) inside a frame, with no T/R before it, ends the frame early. That cycle has `crs_o` and `rxdv_o` low, `rxer_o` high for exactly one clock, and `rxd_o` 0.
- R8: A T followed by anything other than R ends the frame as an invalid symbol. That cycle has `crs_o` and `rxdv_o` low, `rxer_o` high for one clock, and `rxd_o` 4'b1110.
- R9: A code group captured at a rising edge of `clk` drives the outputs from the falling edge that follows that rising edge. The outputs do not change between that falling edge and the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; the code group is sampled on the rising edge and the outputs change on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_i | input | 5 | Aligned, descrambled code group, one per clock |
| rxd_o | output | 4 | Received nibble |
| rxdv_o | output | 1 | Received data valid |
| rxer_o | output | 1 | Receive error |
| crs_o | output | 1 | Carrier sense |

## Verification
The assertions assume that `sym_i` carries a correctly aligned code group at every rising edge. They also assume that `rst` is held high across at least one falling edge, so that the output stage leaves its unknown start-up value before any property is enabled. The bench changes `sym_i` only between rising edges. It holds reset for several full clocks while driving IDLE. The frames it feeds range from well-formed to broken: false carriers, stray code groups in idle, invalid groups inside a frame, early idle, and a T that is not followed by R. This way every path out of each decoder state is taken.

// File: rtl/rx100_pkg.sv
package rx100_pkg;

  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
  localparam logic [NIB_W-1:0] NIB_BAD = 4'b1110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GOT_J,
    ST_FRAME,
    ST_GOT_T
  } rx_state_e;

  typedef enum logic [2:0] {
    CL_DATA,
    CL_J,
    CL_K,
    CL_T,
    CL_R,
    CL_IDLE,
    CL_BAD
  } sym_class_e;

  typedef struct packed {
    logic             dv;
    logic             crs;
    logic             er;
    logic [NIB_W-1:0] rxd;
  } mii_rx_t;

endpackage

// File: rtl/rx100_sym_class.sv
module rx100_sym_class
  import rx100_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output sym_class_e       cls_o,
  output logic [NIB_W-1:0] nib_o
);

  always_comb begin
    cls_o = CL_DATA;
    nib_o = '0;
    unique case (sym_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      CG_J:     cls_o = CL_J;
      CG_K:     cls_o = CL_K;
      CG_T:     cls_o = CL_T;
      CG_R:     cls_o = CL_R;
      CG_IDLE:  cls_o = CL_IDLE;
      default:  cls_o = CL_BAD;
    endcase
  end

endmodule

// File: rtl/rx100_frame_fsm.sv
module rx100_frame_fsm
  import rx100_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  sym_class_e       cls_i,
  input  logic [NIB_W-1:0] nib_i,
  output mii_rx_t          mii_o
);

  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    mii_o   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cls_i == CL_J) begin
          mii_o.dv  = 1'b1;
          mii_o.crs = 1'b1;
          mii_o.rxd = NIB_PRE;
          state_d   = ST_GOT_J;
        end
      end
      ST_GOT_J: begin
        if (cls_i == CL_K) begin
          mii_o.dv  = 1'b1;
          mii_o.crs = 1'b1;
          mii_o.rxd = NIB_PRE;
          state_d   = ST_FRAME;
        end else begin
          mii_o.er  = 1'b1;
          mii_o.rxd = NIB_BAD;
          state_d   = ST_IDLE;
        end
      end
      ST_FRAME: begin
        unique case (cls_i)
          CL_DATA: begin
            mii_o.dv  = 1'b1;
            mii_o.crs = 1'b1;
            mii_o.rxd = nib_i;
          end
          CL_T: begin
            mii_o.crs = 1'b1;
            state_d   = ST_GOT_T;
          end
          CL_IDLE: begin
            mii_o.er = 1'b1;
            state_d  = ST_IDLE;
          end
          default: begin
            mii_o.dv  = 1'b1;
            mii_o.crs = 1'b1;
            mii_o.er  = 1'b1;
            mii_o.rxd = NIB_BAD;
          end
        endcase
      end
      ST_GOT_T: begin
        state_d = ST_IDLE;
        if (cls_i != CL_R) begin
          mii_o.er  = 1'b1;
          mii_o.rxd = NIB_BAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/rx100_mii_oreg.sv
module rx100_mii_oreg
  import rx100_pkg::*;
#(
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  mii_rx_t d_i,
  output mii_rx_t q_o
);

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
      end
    end
  endgenerate

endmodule

// File: rtl/rx100_sym_decoder.sv
module rx100_sym_decoder
  import rx100_pkg::*;
#(
  parameter bit OUT_ON_FALL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] sym_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rxdv_o,
  output logic             rxer_o,
  output logic             crs_o
);

  logic [SYM_W-1:0] sym_q;
  sym_class_e       cls;
  logic [NIB_W-1:0] nib;
  mii_rx_t          mii_d, mii_q;

  always_ff @(posedge clk) begin
    if (rst) sym_q <= CG_IDLE;
    else     sym_q <= sym_i;
  end

  rx100_sym_class u_class (
    .sym_i (sym_q),
    .cls_o (cls),
    .nib_o (nib)
  );

  rx100_frame_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .cls_i (cls),
    .nib_i (nib),
    .mii_o (mii_d)
  );

  rx100_mii_oreg #(.FALL_EDGE(OUT_ON_FALL)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d_i (mii_d),
    .q_o (mii_q)
  );

  assign rxd_o  = mii_q.rxd;
  assign rxdv_o = mii_q.dv;
  assign rxer_o = mii_q.er;
  assign crs_o  = mii_q.crs;

endmodule

// File: rtl/rx100_sym_decoder_chk.sv
module rx100_sym_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] rxd,
  input logic       dv,
  input logic       er,
  input logic       crs
);

  // R2, R6: valid data never appears without carrier
  p_dv_needs_crs_r2: assert property (@(posedge clk) disable iff (rst)
    dv |-> crs);

  // R2: a frame starts with preamble nibble 0x5 and carrier
  p_first_nibble_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dv) |-> (rxd == 4'h5) && crs && !er);

  // R5: an error inside a frame replaces the nibble with 1110
  p_bad_nibble_r5: assert property (@(posedge clk) disable iff (rst)
    (er && dv) |-> rxd == 4'b1110);

  // R1: with no carrier and no error the nibble is zero
  p_quiet_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (!crs && !er) |-> (rxd == 4'h0) && !dv);

  // R7: an error outside carrier lasts one clock only
  p_err_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (er && !crs) |=> !er);

  // R6: carrier goes low only after the T cycle (valid low) or with an error
  p_crs_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(crs) |-> !dv);

endmodule

bind rx100_sym_decoder rx100_sym_decoder_chk u_chk (
  .clk (clk),
  .rst (rst),
  .rxd (rxd_o),
  .dv  (rxdv_o),
  .er  (rxer_o),
  .crs (crs_o)
);

// File: tb/sim_rx100_sym_decoder.sv
`timescale 1ns/1ps
module sim_rx100_sym_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] sym = 5'b11111;
  logic [3:0] rxd;
  logic       rxdv, rxer, crs;

  always #4 clk = ~clk;

  rx100_sym_decoder u0 (
    .clk(clk), .rst(rst), .sym_i(sym),
    .rxd_o(rxd), .rxdv_o(rxdv), .rxer_o(rxer), .crs_o(crs)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // expected output word {dv, crs, er, rxd} and its requirement tag
  logic [6:0] shown_v, pend_v;
  string      shown_t, pend_t;
  int         phase = 0; // 0 quiet, 1 after J, 2 in frame, 3 after T

  logic [4:0] dtab [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                            5'b01010, 5'b01011, 5'b01110, 5'b01111,
                            5'b10010, 5'b10011, 5'b10110, 5'b10111,
                            5'b11010, 5'b11011, 5'b11100, 5'b11101};

  function automatic int data_val(input logic [4:0] s);
    for (int i = 0; i < 16; i++) if (dtab[i] == s) return i;
    return -1;
  endfunction

  task automatic model(input logic [4:0] s, output logic [6:0] v, output string t);
    int d = data_val(s);
    v = 7'b0;
    t = "R1";
    if (phase == 0) begin
      if (s == 5'b11000) begin v = {3'b110, 4'h5}; t = "R2"; phase = 1; end
    end else if (phase == 1) begin
      if (s == 5'b10001) begin v = {3'b110, 4'h5}; t = "R2"; phase = 2; end
      else begin v = {3'b001, 4'b1110}; t = "R3"; phase = 0; end
    end else if (phase == 2) begin
      if (d >= 0) begin v = {3'b110, 4'(d)}; t = "R4"; end
      else if (s == 5'b01101) begin v = {3'b010, 4'h0}; t = "R6"; phase = 3; end
      else if (s == 5'b11111) begin v = {3'b001, 4'h0}; t = "R7"; phase = 0; end
      else begin v = {3'b111, 4'b1110}; t = "R5"; end
    end else begin
      if (s == 5'b00111) begin v = 7'b0; t = "R6"; end
      else begin v = {3'b001, 4'b1110}; t = "R8"; end
      phase = 0;
    end
  endtask

  task automatic compare(input logic [6:0] e, input string t, input string what);
    logic [6:0] a = {rxdv, crs, rxer, rxd};
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s %s: got dv=%b crs=%b er=%b rxd=%h, expected dv=%b crs=%b er=%b rxd=%h",
               t, what, a[6], a[5], a[4], a[3:0], e[6], e[5], e[4], e[3:0]);
    end
  endtask

  task automatic step(input logic [4:0] s);
    logic [6:0] nv;
    string      nt;
    @(posedge clk);
    #2;
    sym = s;
    model(s, nv, nt);
    #1;
    compare(shown_v, "R9", "hold before falling edge");
    #3;
    shown_v = pend_v;
    shown_t = pend_t;
    compare(shown_v, shown_t, "after falling edge");
    pend_v = nv;
    pend_t = nt;
  endtask

  task automatic send_all_data();
    for (int i = 0; i < 16; i++) step(dtab[i]);
  endtask

  initial begin
    shown_v = 7'b0; pend_v = 7'b0;
    shown_t = "R1"; pend_t = "R1";
    repeat (3) @(posedge clk);
    #6;
    compare(7'b0, "R1", "during reset");
    @(posedge clk);
    #2 rst = 1'b0;
    #4 compare(7'b0, "R1", "after reset release");

    // idle with stray code groups (R1)
    step(5'b11111); step(5'b01010); step(5'b10001); step(5'b00111); step(5'b11111);
    // clean frame: J K, preamble, SFD, all data, T R (R2, R4, R6)
    step(5'b11000); step(5'b10001);
    repeat (6) step(5'b01011);
    step(5'b01011); step(5'b11011);
    send_all_data();
    step(5'b01101); step(5'b00111);
    step(5'b11111); step(5'b11111);
    // false carrier: J then data (R3)
    step(5'b11000); step(5'b01110); step(5'b11111);
    // false carrier: J then J (R3)
    step(5'b11000); step(5'b11000); step(5'b11111);
    // frame with invalid groups then early idle (R5, R7)
    step(5'b11000); step(5'b10001); step(5'b01011);
    step(5'b00000); step(5'b01001); step(5'b11000); step(5'b00111); step(5'b10001);
    step(5'b11101); step(5'b11111); step(5'b11111);
    // T followed by non-R (R8)
    step(5'b11000); step(5'b10001); step(5'b10100);
    step(5'b01101); step(5'b10100); step(5'b11111);
    // T followed by IDLE (R8)
    step(5'b11000); step(5'b10001); step(5'b01101); step(5'b11111);
    // back-to-back frame after clean end
    step(5'b11000); step(5'b10001); step(5'b11100); step(5'b01101); step(5'b00111);
    step(5'b11000); step(5'b10001); step(5'b01111); step(5'b01101); step(5'b00111);
    repeat (3) step(5'b11111);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule